// File: doc/BRIEF.md
# Configurable Packet Transmit Framer

This block serialises one radio packet at a time. Control logic provides static settings: preamble length, sync pattern and its length, up to four header bytes, payload length, CRC options, bit order and line coding. A pulse on `start` then begins a packet. The framer puts out one line bit for each cycle in which the bit-clock enable is high. It takes payload bytes from a ready/valid byte source exactly when the serialiser reaches them, and it pulses `done` once the last bit has gone out.

The packet is sent in this order: a preamble counted in 4-bit units, one to four sync bytes, zero to four header bytes, an optional length byte, the payload, and an optional 16-bit CRC. Multi-byte fields always start from their most significant byte. Manchester coding can be applied to everything, including the preamble. If the payload source has no byte ready at the moment one is needed, the packet is cut short and a sticky underflow flag is raised.

Top module: `pkt_tx_framer`

## Requirements
- R1: After reset the framer is idle: `busy`, `tx_bit`, `pay_ready`, `done` and `underflow` are all 0. While idle, `tx_bit` and `pay_ready` stay 0.
- R2: A `start` sampled while idle makes `busy` high on the next cycle. A `start` while busy is ignored, and the packet in progress is unchanged.
- R3: The preamble lasts 4*N bits, where N is `cfg_pre_nib`; N=0 acts as 1. Without Manchester coding it alternates 1,0,1,0… beginning with 1.
- R4: Sync byte count is `cfg_sync_len`+1. Bytes are taken from `cfg_sync_word` bits 31:24 first and then downward.
- R5: Header byte count is `cfg_hdr_len`, with codes above 4 acting as 4. Bytes are taken from `cfg_hdr_word` bits 31:24 first and then downward.
- R6: When `cfg_fixed_len` is 0, a byte equal to `cfg_pay_len` follows the header. Exactly `cfg_pay_len` payload bytes (0 to 255) are then sent from the stream, and each byte is accepted in a cycle where `pay_ready` and `pay_valid` are both 1.
- R7: When `cfg_crc_en` is 1, a 16-bit CRC follows the payload, high byte first. It is non-reflected, has no final XOR, and is fed each byte value MSB first. `cfg_crc_sel`=01 uses polynomial 8005h with initial value 0000h; every other code uses 1021h with initial value FFFFh. The CRC covers header, length and payload bytes, or only the payload bytes when `cfg_crc_pay` is 1.
- R8: Each byte is sent MSB first, or LSB first when `cfg_lsb_first` is 1.
- R9: With `cfg_manch` set, each bit becomes two line chips: 1 is sent as 0 then 1, and 0 as 1 then 0. `cfg_manch_inv` swaps the two. Every preamble bit is then equal to `cfg_pre_pol`.
- R10: `done` is high for exactly one cycle, in the first cycle in which `busy` is low after the last chip of a complete packet.
- R11: If `pay_valid` is 0 when a payload byte is needed, `busy` drops, no `done` is given, and `underflow` is set. `underflow` stays set until the next accepted `start`.
- R12: One chip is consumed per cycle with `bit_en` high. `tx_bit` holds its value through cycles with `bit_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-clock enable; consumes the current chip |
| start | input | 1 | Begin a packet (when idle) |
| cfg_pre_nib | input | 9 | Preamble length in nibbles |
| cfg_sync_len | input | 2 | Sync byte count minus one |
| cfg_sync_word | input | 32 | Sync pattern, sent from bits 31:24 down |
| cfg_hdr_len | input | 3 | Header byte count (0..4) |
| cfg_hdr_word | input | 32 | Header bytes, sent from bits 31:24 down |
| cfg_fixed_len | input | 1 | 1 omits the length byte |
| cfg_pay_len | input | 8 | Payload byte count |
| cfg_crc_en | input | 1 | Append CRC |
| cfg_crc_pay | input | 1 | CRC covers payload only |
| cfg_crc_sel | input | 2 | CRC polynomial code |
| cfg_lsb_first | input | 1 | Send bytes LSB first |
| cfg_manch | input | 1 | Enable Manchester coding |
| cfg_manch_inv | input | 1 | Swap Manchester chip order |
| cfg_pre_pol | input | 1 | Manchester preamble bit value |
| pay_data | input | 8 | Payload byte |
| pay_valid | input | 1 | Payload byte available |
| pay_ready | output | 1 | Payload byte taken this cycle |
| tx_bit | output | 1 | Current line chip |
| busy | output | 1 | Packet in progress |
| done | output | 1 | One-cycle end-of-packet pulse |
| underflow | output | 1 | Sticky payload underflow flag |

## Verification
The properties assume that every `cfg_*` input is held steady while `busy` is high. They also assume that a payload byte, once presented, stays on `pay_data` until the edge that accepts it. The stimulus changes configuration only between packets, when the framer is idle. It updates `pay_data` only on the falling edge after a cycle in which `pay_ready` was seen. Bit-clock enables are randomised so that gaps of any length appear between consumed chips, and one mid-packet `start` is issued on purpose to confirm it is ignored.

// File: rtl/pkt_tx_framer.sv
module pkt_tx_framer #(
  parameter int PRE_W = 9,
  localparam int PCNT_W = PRE_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             start,
  input  logic [PRE_W-1:0] cfg_pre_nib,
  input  logic [1:0]       cfg_sync_len,
  input  logic [31:0]      cfg_sync_word,
  input  logic [2:0]       cfg_hdr_len,
  input  logic [31:0]      cfg_hdr_word,
  input  logic             cfg_fixed_len,
  input  logic [7:0]       cfg_pay_len,
  input  logic             cfg_crc_en,
  input  logic             cfg_crc_pay,
  input  logic [1:0]       cfg_crc_sel,
  input  logic             cfg_lsb_first,
  input  logic             cfg_manch,
  input  logic             cfg_manch_inv,
  input  logic             cfg_pre_pol,
  input  logic [7:0]       pay_data,
  input  logic             pay_valid,
  output logic             pay_ready,
  output logic             tx_bit,
  output logic             busy,
  output logic             done,
  output logic             underflow
);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_SYNC, S_HDR, S_LEN, S_PAY, S_CRC} st_t;

  st_t st, nst;
  logic [PCNT_W-1:0] pcnt;
  logic [2:0] bidx;
  logic [7:0] bnum, nnum, cur, nbyte;
  logic chip;
  logic [15:0] crc;

  wire alt_poly = (cfg_crc_sel == 2'b01);
  wire [PRE_W-1:0] pre_units = (cfg_pre_nib == '0) ? PRE_W'(1) : cfg_pre_nib;
  wire [PCNT_W-1:0] pre_last = {pre_units - PRE_W'(1), 2'b11};
  wire [2:0] hdr_n = (cfg_hdr_len > 3'd4) ? 3'd4 : cfg_hdr_len;

  assign busy = (st != S_IDLE);

  wire d_bit = (st == S_PRE) ? (cfg_manch ? cfg_pre_pol : ~pcnt[0])
                             : (cfg_lsb_first ? cur[bidx] : cur[3'd7 - bidx]);
  assign tx_bit = busy & (cfg_manch ? (chip ? (d_bit ^ cfg_manch_inv) : (~d_bit ^ cfg_manch_inv))
                                    : d_bit);

  wire bit_done = busy & bit_en & (~cfg_manch | chip);
  wire last_bit = (st == S_PRE) ? (pcnt == pre_last) : (bidx == 3'd7);
  wire need_pay = (nst == S_PAY);
  wire covered  = (nst == S_PAY) | (~cfg_crc_pay & ((nst == S_HDR) | (nst == S_LEN)));

  assign pay_ready = bit_done & last_bit & need_pay;

  function automatic logic [7:0] pick(input logic [31:0] w, input logic [1:0] i);
    case (i)
      2'd0:    pick = w[31:24];
      2'd1:    pick = w[23:16];
      2'd2:    pick = w[15:8];
      default: pick = w[7:0];
    endcase
  endfunction

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b, input logic alt);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ b[i];
      r  = {r[14:0], 1'b0} ^ (fb ? (alt ? 16'h8005 : 16'h1021) : 16'h0000);
    end
    return r;
  endfunction

  always_comb begin
    logic [2:0] t;
    nst = S_IDLE;
    nnum = 8'd0;
    t = 3'd0;
    case (st)
      S_PRE:  nst = S_SYNC;
      S_SYNC: if (bnum != {6'd0, cfg_sync_len}) begin nst = S_SYNC; nnum = bnum + 8'd1; end
              else t = 3'd1;
      S_HDR:  if (bnum + 8'd1 < {5'd0, hdr_n}) begin nst = S_HDR; nnum = bnum + 8'd1; end
              else t = 3'd2;
      S_LEN:  t = 3'd3;
      S_PAY:  if (bnum != cfg_pay_len - 8'd1) begin nst = S_PAY; nnum = bnum + 8'd1; end
              else t = 3'd4;
      S_CRC:  if (bnum == 8'd0) begin nst = S_CRC; nnum = 8'd1; end
      default: ;
    endcase
    if (t == 3'd1) begin if (hdr_n != 3'd0) begin nst = S_HDR; t = 3'd0; end else t = 3'd2; end
    if (t == 3'd2) begin if (!cfg_fixed_len) begin nst = S_LEN; t = 3'd0; end else t = 3'd3; end
    if (t == 3'd3) begin if (cfg_pay_len != 8'd0) begin nst = S_PAY; t = 3'd0; end else t = 3'd4; end
    if (t == 3'd4 && cfg_crc_en) nst = S_CRC;
  end

  always_comb begin
    case (nst)
      S_SYNC:  nbyte = pick(cfg_sync_word, nnum[1:0]);
      S_HDR:   nbyte = pick(cfg_hdr_word, nnum[1:0]);
      S_LEN:   nbyte = cfg_pay_len;
      S_PAY:   nbyte = pay_data;
      S_CRC:   nbyte = (nnum == 8'd0) ? crc[15:8] : crc[7:0];
      default: nbyte = 8'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      pcnt <= '0;
      bidx <= 3'd0;
      bnum <= 8'd0;
      cur <= 8'd0;
      chip <= 1'b0;
      crc <= 16'hFFFF;
      done <= 1'b0;
      underflow <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        if (start) begin
          st <= S_PRE;
          pcnt <= '0;
          chip <= 1'b0;
          crc <= alt_poly ? 16'h0000 : 16'hFFFF;
          underflow <= 1'b0;
        end
      end else if (bit_en) begin
        if (cfg_manch && !chip) begin
          chip <= 1'b1;
        end else begin
          chip <= 1'b0;
          if (last_bit) begin
            if (need_pay && !pay_valid) begin
              st <= S_IDLE;
              underflow <= 1'b1;
            end else begin
              st <= nst;
              bnum <= nnum;
              bidx <= 3'd0;
              cur <= nbyte;
              if (covered) crc <= crc_step(crc, nbyte, alt_poly);
              if (nst == S_IDLE) done <= 1'b1;
            end
          end else if (st == S_PRE) begin
            pcnt <= pcnt + PCNT_W'(1);
          end else begin
            bidx <= bidx + 3'd1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/pkt_tx_framer_sva.sv
module pkt_tx_framer_sva (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic start,
  input logic cfg_manch,
  input logic chip,
  input logic busy,
  input logic done,
  input logic underflow,
  input logic pay_ready,
  input logic tx_bit
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!tx_bit && !pay_ready));

  assert_start_begins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  assert_ready_in_packet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pay_ready |-> (busy && bit_en));

  assert_mid_bit_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_manch && bit_en && !chip) |=> (tx_bit != $past(tx_bit)));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_underflow_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underflow) |-> (!busy && $past(busy) && !done));

  assert_underflow_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !(start && !busy)) |=> underflow);

  assert_hold_tx_bit_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_en) |=> $stable(tx_bit));

endmodule

bind pkt_tx_framer pkt_tx_framer_sva u_sva (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .start(start),
  .cfg_manch(cfg_manch), .chip(chip), .busy(busy), .done(done),
  .underflow(underflow), .pay_ready(pay_ready), .tx_bit(tx_bit)
);

// File: tb/pkt_tx_framer_tb.sv
module pkt_tx_framer_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, bit_en, start;
  logic [8:0] cfg_pre_nib;
  logic [1:0] cfg_sync_len, cfg_crc_sel;
  logic [31:0] cfg_sync_word, cfg_hdr_word;
  logic [2:0] cfg_hdr_len;
  logic cfg_fixed_len, cfg_crc_en, cfg_crc_pay, cfg_lsb_first;
  logic cfg_manch, cfg_manch_inv, cfg_pre_pol;
  logic [7:0] cfg_pay_len, pay_data;
  logic pay_valid, pay_ready, tx_bit, busy, done, underflow;

  pkt_tx_framer u_dut (.*);

  int n_chk = 0, n_fail = 0;
  logic [7:0] payload [256];
  logic exp_q[$];
  logic got_q[$];
  int mark;
  int en_pct;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  function automatic logic [15:0] crc_model(input logic [15:0] c, input logic [7:0] b, input bit alt);
    logic [15:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      logic fb = r[15] ^ b[i];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ (alt ? 16'h8005 : 16'h1021);
    end
    return r;
  endfunction

  task automatic push_bit(input logic d);
    if (cfg_manch) begin
      exp_q.push_back(~d ^ cfg_manch_inv);
      exp_q.push_back(d ^ cfg_manch_inv);
    end else exp_q.push_back(d);
  endtask

  task automatic push_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) push_bit(cfg_lsb_first ? b[i] : b[7-i]);
  endtask

  task automatic build_expected(input int drop_at);
    int units, hn;
    bit alt;
    logic [15:0] c;
    exp_q.delete();
    mark = -1;
    alt = (cfg_crc_sel == 2'b01);
    c = alt ? 16'h0000 : 16'hFFFF;
    units = (cfg_pre_nib == 0) ? 1 : int'(cfg_pre_nib);
    for (int i = 0; i < units*4; i++) push_bit(cfg_manch ? cfg_pre_pol : ((i % 2) == 0));
    for (int j = 0; j <= int'(cfg_sync_len); j++) push_byte(cfg_sync_word[31-8*j -: 8]);
    hn = (cfg_hdr_len > 4) ? 4 : int'(cfg_hdr_len);
    for (int j = 0; j < hn; j++) begin
      push_byte(cfg_hdr_word[31-8*j -: 8]);
      if (!cfg_crc_pay) c = crc_model(c, cfg_hdr_word[31-8*j -: 8], alt);
    end
    if (!cfg_fixed_len) begin
      push_byte(cfg_pay_len);
      if (!cfg_crc_pay) c = crc_model(c, cfg_pay_len, alt);
    end
    for (int j = 0; j < int'(cfg_pay_len); j++) begin
      if (j == drop_at) mark = exp_q.size();
      push_byte(payload[j]);
      c = crc_model(c, payload[j], alt);
    end
    if (cfg_crc_en) begin
      push_byte(c[15:8]);
      push_byte(c[7:0]);
    end
  endtask

  task automatic run_pkt(input string tag, input int drop_at, input int start_mid);
    int pidx = 0, rdy = 0, dn = 0, cyc = 0, bad = 0, first_bad = -1, cmp_n;
    build_expected(drop_at);
    got_q.delete();
    @(negedge clk);
    start = 1'b1;
    pay_data = payload[0];
    pay_valid = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2", "busy after start", busy, 1);
    forever begin
      if (done) dn++;
      if (!busy) break;
      if (cyc > 30000) begin
        check(1'b0, tag, "packet never ended", cyc, 0);
        break;
      end
      bit_en = (($urandom % 100) < en_pct);
      pay_valid = (pidx != drop_at);
      pay_data = payload[pidx % 256];
      start = (start_mid != 0 && cyc == start_mid);
      #1;
      if (busy && bit_en) got_q.push_back(tx_bit);
      if (pay_ready) begin
        pidx++;
        rdy++;
      end
      @(negedge clk);
      cyc++;
    end
    bit_en = 1'b0;
    start = 1'b0;
    if (drop_at < 0) begin
      check(got_q.size() == exp_q.size(), tag, "chip count", got_q.size(), exp_q.size());
      cmp_n = exp_q.size();
      check(dn == 1, "R10", "done pulses", dn, 1);
      check(rdy == int'(cfg_pay_len), "R6", "payload bytes taken", rdy, cfg_pay_len);
      check(underflow == 1'b0, "R11", "underflow on good packet", underflow, 0);
    end else begin
      check(underflow == 1'b1, "R11", "underflow flag", underflow, 1);
      check(dn == 0, "R11", "done on aborted packet", dn, 0);
      check(got_q.size() == mark, "R11", "chips before abort", got_q.size(), mark);
      cmp_n = mark;
    end
    for (int i = 0; i < cmp_n && i < got_q.size(); i++)
      if (got_q[i] !== exp_q[i]) begin
        bad++;
        if (first_bad < 0) first_bad = i;
      end
    check(bad == 0, tag, "chip mismatches", bad, 0);
    if (bad != 0) $display("  first mismatch at chip %0d", first_bad);
    @(negedge clk);
    check(done == 1'b0, "R10", "done after one cycle", done, 0);
  endtask

  task automatic set_defaults();
    cfg_pre_nib = 9'd8; cfg_sync_len = 2'd1; cfg_sync_word = 32'h2DD40000;
    cfg_hdr_len = 3'd4; cfg_hdr_word = 32'hA1B2C3D4; cfg_fixed_len = 1'b0;
    cfg_pay_len = 8'd5; cfg_crc_en = 1'b1; cfg_crc_pay = 1'b0; cfg_crc_sel = 2'd0;
    cfg_lsb_first = 1'b0; cfg_manch = 1'b0; cfg_manch_inv = 1'b0; cfg_pre_pol = 1'b0;
    en_pct = 50;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R12 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bit_en = 1'b0; start = 1'b0; pay_valid = 1'b0; pay_data = 8'd0;
    set_defaults();
    for (int i = 0; i < 256; i++) payload[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !tx_bit && !pay_ready && !done && !underflow, "R1", "reset outputs",
          {busy, tx_bit, pay_ready, done, underflow}, 0);

    run_pkt("R3 R4 R5 R6 R7", -1, 0);

    set_defaults();
    cfg_pre_nib = 9'd0; cfg_sync_len = 2'd0; cfg_hdr_len = 3'd0;
    cfg_fixed_len = 1'b1; cfg_pay_len = 8'd0; cfg_crc_en = 1'b0;
    run_pkt("R3", -1, 0);

    set_defaults();
    cfg_hdr_len = 3'd7; cfg_sync_len = 2'd3; cfg_sync_word = 32'h12345678;
    cfg_crc_sel = 2'd1; cfg_crc_pay = 1'b1; cfg_pay_len = 8'd3;
    run_pkt("R4 R5 R7", -1, 0);

    set_defaults();
    cfg_crc_sel = 2'd2; cfg_lsb_first = 1'b1; cfg_hdr_len = 3'd2;
    run_pkt("R7 R8", -1, 0);

    set_defaults();
    cfg_manch = 1'b1; cfg_pre_pol = 1'b1;
    run_pkt("R9", -1, 0);

    set_defaults();
    cfg_manch = 1'b1; cfg_manch_inv = 1'b1; cfg_pre_pol = 1'b0; cfg_pre_nib = 9'd3;
    run_pkt("R9", -1, 0);

    set_defaults();
    run_pkt("R2", -1, 60);

    set_defaults();
    cfg_fixed_len = 1'b1;
    run_pkt("R11", 2, 0);
    set_defaults();
    run_pkt("R11", -1, 0);

    set_defaults();
    en_pct = 100;
    run_pkt("R12", -1, 0);

    for (int k = 0; k < 10; k++) begin
      cfg_pre_nib = 9'($urandom % 32); cfg_sync_len = 2'($urandom);
      cfg_sync_word = $urandom; cfg_hdr_len = 3'($urandom); cfg_hdr_word = $urandom;
      cfg_fixed_len = 1'($urandom); cfg_pay_len = 8'($urandom % 25);
      cfg_crc_en = 1'($urandom); cfg_crc_pay = 1'($urandom); cfg_crc_sel = 2'($urandom);
      cfg_lsb_first = 1'($urandom); cfg_manch = 1'($urandom);
      cfg_manch_inv = 1'($urandom); cfg_pre_pol = 1'($urandom);
      en_pct = 20 + int'($urandom % 80);
      for (int i = 0; i < 256; i++) payload[i] = 8'($urandom);
      run_pkt("R12", -1, 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule